// File: doc/BRIEF.md
# Interrupt mask and status controller

This block gathers thirty event sources from a network MAC into a single interrupt line. Each source owns one status bit, which latches a one-cycle event pulse, and one mask bit, which decides whether that latched event may drive the interrupt output. Software sees four word addresses on a simple register bus: the status word, the mask word, a set of enable strobes and a set of disable strobes.

The mask is never written directly. Software writes ones to the enable address to unmask sources, or ones to the disable address to mask them. Zero bits in either write leave their mask bits alone, so no read-modify-write is needed. A write to the mask address does not change the mask. Instead, it forces the matching status bits high, whatever the mask holds. This lets a test raise any interrupt without the MAC. Reading the status word returns it and clears it.

Six positions carry no source: 8, 9, 15, 16, 17 and 28. At these positions the mask stays at one and the status stays at zero.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the mask word reads 0x3FFF_FFFF, the status word reads 0 and the interrupt output is low.
- R2: A status bit drives the interrupt only when its mask bit is 0. A mask bit of 1 keeps that source from the interrupt.
- R3: A write to the enable address (word 2) clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R4: A write to the disable address (word 3) sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R5: A write to the mask address (word 1) never changes the mask.
- R6: A write to the mask address sets each status bit whose data bit is 1, whatever the mask holds. An unmasked forced bit then raises the interrupt.
- R7: Positions 8, 9, 15, 16, 17 and 28, and data bits 30 and 31, have no effect. At these six positions the mask reads 1 and the status reads 0, whatever is written or pulsed.
- R8: An event pulse on source bit i sets status bit i on the next clock edge. The bit then holds until it is cleared by a read.
- R9: Reading the status address (word 0) returns the status word in the same cycle and clears it at the clock edge. An event that arrives in the same cycle as the read leaves its bit set.
- R10: The interrupt output is registered. It reflects the status and mask state one clock edge after that state changes.
- R11: Reading the enable address, the disable address, or any address other than words 0 and 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 30 | One-cycle event pulses, one per source bit |
| bus_addr | input | ADDR_W (4) | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle the read strobe is high |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two things can fall in the same cycle: a read of the status word, which clears it, and a new event pulse or forced set on a bit. The bench provokes this on purpose with a status read that carries a simultaneous pulse. It then also does so by chance, through random cycles that mix reads, strobe writes and event pulses. It judges each cycle with its own model, in which a set wins over the clear. It compares both the value read in that cycle and the status seen on the following read.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned NSRC = 30;
  // positions carrying a real source; 8, 9, 15, 16, 17 and 28 are empty
  localparam logic [NSRC-1:0] SRC_LIVE = 30'h2FFC_7CFF;
  localparam logic [NSRC-1:0] MASK_RST = '1;

  localparam int unsigned WORD_STATUS  = 0;
  localparam int unsigned WORD_MASK    = 1;
  localparam int unsigned WORD_ENABLE  = 2;
  localparam int unsigned WORD_DISABLE = 3;

  function automatic logic [NSRC-1:0] mask_next_f(
    input logic [NSRC-1:0] cur,
    input logic            en_stb,
    input logic            dis_stb,
    input logic [NSRC-1:0] bits
  );
    logic [NSRC-1:0] m;
    m = cur;
    if (en_stb)  m = m & ~(bits & SRC_LIVE);
    if (dis_stb) m = m |  (bits & SRC_LIVE);
    return m | ~SRC_LIVE;
  endfunction

  function automatic logic [NSRC-1:0] status_next_f(
    input logic [NSRC-1:0] cur,
    input logic            clr_stb,
    input logic [NSRC-1:0] evt,
    input logic            frc_stb,
    input logic [NSRC-1:0] bits
  );
    logic [NSRC-1:0] s;
    s = clr_stb ? '0 : cur;
    s = s | evt;
    if (frc_stb) s = s | bits;
    return s & SRC_LIVE;
  endfunction

  function automatic logic pending_f(
    input logic [NSRC-1:0] stat,
    input logic [NSRC-1:0] mask
  );
    return |(stat & ~mask);
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   mask,
  input  logic [NSRC-1:0]   status,
  output logic              en_stb,
  output logic              dis_stb,
  output logic              frc_stb,
  output logic              clr_stb,
  output logic [NSRC-1:0]   bits,
  output logic [DATA_W-1:0] rdata
);

  logic hit_status, hit_mask, hit_enable, hit_disable;
  logic unused_wdata_hi;

  assign hit_status  = (addr == ADDR_W'(WORD_STATUS));
  assign hit_mask    = (addr == ADDR_W'(WORD_MASK));
  assign hit_enable  = (addr == ADDR_W'(WORD_ENABLE));
  assign hit_disable = (addr == ADDR_W'(WORD_DISABLE));

  assign en_stb  = wr & hit_enable;
  assign dis_stb = wr & hit_disable;
  assign frc_stb = wr & hit_mask;
  assign clr_stb = rd & hit_status;
  assign bits    = wdata[NSRC-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:NSRC];

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_status)    rdata = DATA_W'(status);
      else if (hit_mask) rdata = DATA_W'(mask);
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_stb,
  input  logic            dis_stb,
  input  logic [NSRC-1:0] bits,
  output logic [NSRC-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= MASK_RST;
    else        mask <= mask_next_f(mask, en_stb, dis_stb, bits);
  end

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_stb && !dis_stb |=> (mask & $past(bits & SRC_LIVE)) == '0); // R3

  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> (mask & $past(bits & SRC_LIVE)) == $past(bits & SRC_LIVE)); // R4

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_stb && !dis_stb |=> $stable(mask)); // R5

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_stb,
  input  logic [NSRC-1:0] evt,
  input  logic            frc_stb,
  input  logic [NSRC-1:0] bits,
  output logic [NSRC-1:0] status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_next_f(status, clr_stb, evt, frc_stb, bits);
  end

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    |evt |=> (status & $past(evt & SRC_LIVE)) == $past(evt & SRC_LIVE)); // R8

  AST_FORCE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    frc_stb |=> (status & $past(bits & SRC_LIVE)) == $past(bits & SRC_LIVE)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb && (evt == '0) && !frc_stb |=> status == '0); // R9

  AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> (status & $past(status)) == $past(status)); // R8

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic              en_stb, dis_stb, frc_stb, clr_stb;
  logic [NSRC-1:0]   bits;
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   status;
  logic              pend;
  logic              irq_q;

  irq_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .mask    (mask),
    .status  (status),
    .en_stb  (en_stb),
    .dis_stb (dis_stb),
    .frc_stb (frc_stb),
    .clr_stb (clr_stb),
    .bits    (bits),
    .rdata   (bus_rdata)
  );

  irq_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_stb  (en_stb),
    .dis_stb (dis_stb),
    .bits    (bits),
    .mask    (mask)
  );

  irq_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_stb (clr_stb),
    .evt     (evt_i),
    .frc_stb (frc_stb),
    .bits    (bits),
    .status  (status)
  );

  assign pend = pending_f(status, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend;
  end

  assign irq_o = irq_q;

  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask) == MASK_RST |-> !irq_o); // R2

  AST_NOTHING_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status) == '0 |-> !irq_o); // R10

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R11

endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;

  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [29:0]   evt_i = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  always #10 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [29:0] m_mask, m_stat;
  logic        m_irq;

  function automatic logic [29:0] live_bits();
    logic [29:0] v;
    for (int i = 0; i < 30; i++)
      v[i] = !(i == 8 || i == 9 || i == 15 || i == 16 || i == 17 || i == 28);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    if (a == 0) return {2'b00, m_stat};
    if (a == 1) return {2'b00, m_mask};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus/event cycle: check irq, drive, check read data, advance model
  task automatic cyc(input logic [29:0] e, input logic [AW-1:0] a, input logic w,
                     input logic [31:0] d, input logic r, input string tag);
    logic [29:0] lv, os, om;
    @(negedge clk);
    chk({tag, " R10 irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    evt_i = e; bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
    #1;
    if (r) chk({tag, " read"}, bus_rdata, exp_read(a));
    @(posedge clk);
    lv = live_bits();
    os = m_stat; om = m_mask;
    m_irq = |(os & ~om);
    if (w && a == 2) m_mask = m_mask & ~(d[29:0] & lv);
    if (w && a == 3) m_mask = m_mask | (d[29:0] & lv);
    if (r && a == 0) m_stat = '0;
    m_stat = m_stat | (e & lv);
    if (w && a == 1) m_stat = m_stat | (d[29:0] & lv);
    #1;
    evt_i = '0; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(input string tag);
    cyc('0, '0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_mask = 30'h3FFF_FFFF; m_stat = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R1 mask");
    chk("R1 mask const", {2'b0, m_mask}, 32'h3FFF_FFFF);
    cyc('0, 4'd0, 1'b0, '0, 1'b1, "R1 status");

    // R5 write to mask address with zero data: mask untouched
    cyc('0, 4'd1, 1'b1, 32'h0, 1'b0, "R5");
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R5 mask");

    // R3 enable bits 0,1 ; R11 reads of strobe addresses
    cyc('0, 4'd2, 1'b1, 32'h0000_0003, 1'b0, "R3");
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R3 mask");
    chk("R3 mask const", {2'b0, m_mask}, 32'h3FFF_FFFC);
    cyc('0, 4'd2, 1'b0, '0, 1'b1, "R11 enable");
    cyc('0, 4'd3, 1'b0, '0, 1'b1, "R11 disable");
    cyc('0, 4'd9, 1'b0, '0, 1'b1, "R11 other");

    // R8 and R2: masked source 5 alone, no irq
    cyc(30'h20, '0, 1'b0, '0, 1'b0, "R8 masked");
    idle("R2 masked"); idle("R2 masked");
    chk("R2 masked no irq", {31'b0, irq_o}, 32'h0);
    cyc(30'h1, '0, 1'b0, '0, 1'b0, "R8 bit0");
    idle("R10"); idle("R10");
    chk("R2 enabled irq", {31'b0, irq_o}, 32'h1);

    // R9 read with simultaneous event on bit 1
    cyc(30'h2, 4'd0, 1'b0, '0, 1'b1, "R9 collide");
    cyc('0, 4'd0, 1'b0, '0, 1'b1, "R9 after");
    chk("R9 kept bit", {2'b0, m_stat}, 32'h0);
    idle("R9"); idle("R9");

    // R4 disable bit 0
    cyc('0, 4'd3, 1'b1, 32'h0000_0001, 1'b0, "R4");
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R4 mask");

    // R6 and R7: force everything through mask address
    cyc('0, 4'd1, 1'b1, 32'hFFFF_FFFF, 1'b0, "R6");
    idle("R6"); idle("R6");
    chk("R6 irq raised", {31'b0, irq_o}, 32'h1);
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R5 after force");
    cyc('0, 4'd0, 1'b0, '0, 1'b1, "R7 status");
    chk("R7 status const", {2'b0, m_stat}, 32'h0);
    cyc(30'h3FFF_FFFF, '0, 1'b0, '0, 1'b0, "R7 events");
    cyc('0, 4'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, "R7 enable all");
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R7 mask");
    chk("R7 mask const", {2'b0, m_mask}, 32'h1003_8300);
    cyc('0, 4'd0, 1'b0, '0, 1'b1, "R7 status all");
    cyc('0, 4'd3, 1'b1, 32'hFFFF_FFFF, 1'b0, "R4 disable all");
    cyc('0, 4'd1, 1'b0, '0, 1'b1, "R4 mask all");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [29:0] e;
      logic [AW-1:0] a;
      logic w, r;
      logic [31:0] d;
      e = ($urandom() & $urandom() & $urandom()) & 32'h3FFF_FFFF;
      if ($urandom_range(0, 2) == 0) e = '0;
      a = AW'($urandom_range(0, 4));
      w = ($urandom_range(0, 2) == 0);
      r = ($urandom_range(0, 1) == 0);
      d = $urandom() & $urandom();
      cyc(e, a, w, d, r, "R9 random");
    end
    idle("R10 final"); idle("R10 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule